// File: doc/BRIEF.md
# Second-Order One-Bit Sigma-Delta Modulator

This block converts a held unsigned DAC code into a one-bit pulse-density stream. Downstream, that stream switches a current source, and an external RC network averages it. The loop has two integrators in cascade and a sign quantizer. A full-scale feedback term is subtracted from both integrators whenever the previous output bit was one. Over a long run, the fraction of ones therefore equals the code divided by 2^CODE_W. With the default 17-bit code, full scale maps to 32 mA, and normal-mode codes sit in the 4–20 mA window.

The loop only advances on cycles where the oscillator tick `osc_tick` is high. A small controller sequences it through three states:

- **OFF**: the loop is cleared. It moves to **ARM** in the cycle after `run_en` is seen high.
- **ARM**: the first tick only captures the code. It then moves to **RUN**.
- **RUN**: every tick performs one modulator step using the code captured at the previous tick, and then captures a new code.

Dropping `run_en` returns the controller to **OFF** from any state. It also clears both integrators, the captured code and the output bit.

Top module: `sd2_modulator`

## Requirements
- R1: With a constant code `c` and a tick on every cycle, the count of ones in the first 2^CODE_W RUN steps is within ±2 of `c`, for codes between 1/8 and 7/8 of full scale.
- R2: For two constant codes at least 8 apart in that range, the larger code gives strictly more ones over the same 2^CODE_W-step window.
- R3: With code 0, `bit_out` stays 0 for every step.
- R4: Each RUN tick computes, from the previous bit `b` and with `fb = b ? 2^CODE_W : 0`:
  - `i1 += x - fb`, then `i2 += i1 - fb`, where `x` is the code captured at the previous tick;
  - the new bit is 1 exactly when the updated `i2 > 0`.

  The code is captured only on tick cycles, so changes between ticks have no effect.
- R5: A cycle with `run_en` low clears both integrators, the captured code and the bit, even when a tick falls in the same cycle. A later re-enable behaves exactly like a fresh start.
- R6: While `run_en` is low, `bit_out` is 0 whatever `osc_tick` and `code_in` do.
- R7: The signed integrators of width ACC_W never wrap for codes between 1/8 and 7/8 of full scale. The stream therefore matches unbounded-precision arithmetic.
- R8: After enable, the controller behaves as follows:
  - the first edge with `run_en` high only enters ARM, and a tick in that cycle is ignored;
  - the first tick in ARM captures the code without stepping;
  - each later tick steps the loop.
- R9: After reset, `bit_out` is 0 and the controller is in OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enable; low clears and stops the loop |
| osc_tick | input | 1 | Modulator clock-enable from the local oscillator |
| code_in | input | CODE_W | Unsigned latched DAC code |
| bit_out | output | 1 | One-bit density stream |

## Verification
The disable and the oscillator tick can land in the same cycle, and the disable must win. The bench provokes this by dropping `run_en` for exactly one cycle while `osc_tick` is high in the middle of a running stream. It then judges two things: that `bit_out` reads 0 right after that edge, and that every following bit matches a freshly started arithmetic model. In a second case, a code change and a tick fall together. That case is judged by the stream following the code captured at the tick edge, not the values written between ticks.

// File: rtl/sd2_pkg.sv
`timescale 1ns/1ps
package sd2_pkg;
    // Number of cascaded integrators in the loop.
    localparam int LOOP_ORDER = 2;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } sd2_state_e;
endpackage

// File: rtl/sd2_ctrl.sv
`timescale 1ns/1ps
module sd2_ctrl
    import sd2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       tick,
    output logic       clear,
    output logic       load,
    output logic       step,
    output sd2_state_e state
);
    sd2_state_e state_nx;

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  state_nx = ST_ARM;
            ST_ARM:  state_nx = tick ? ST_RUN : ST_ARM;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_OFF;
        endcase
        if (!run_en) state_nx = ST_OFF;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Output decode.
    always_comb begin
        clear = !run_en;
        load  = 1'b0;
        step  = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_ARM: load = run_en && tick;
            ST_RUN: begin
                load = run_en && tick;
                step = run_en && tick;
            end
            default: ;
        endcase
    end

    p_enter_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && run_en) |=> (state == ST_ARM));
    p_arm_to_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && run_en && tick) |=> (state == ST_RUN));
    p_drop_to_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state == ST_OFF));
endmodule

// File: rtl/sd2_integ.sv
`timescale 1ns/1ps
module sd2_integ #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] inc,
    output logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] acc_nx
);
    assign acc_nx = acc + inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (en)    acc <= acc_nx;
    end

    // Operands of equal sign must not produce a result of the other sign.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear) |->
        !((acc[ACC_W-1] == inc[ACC_W-1]) && (acc_nx[ACC_W-1] != acc[ACC_W-1])));
    p_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));
endmodule

// File: rtl/sd2_quant.sv
`timescale 1ns/1ps
module sd2_quant #(
    parameter int ACC_W  = 24,
    parameter int CODE_W = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic signed [ACC_W-1:0] last_nx,
    output logic                    bit_q,
    output logic signed [ACC_W-1:0] fb
);
    localparam logic [ACC_W-1:0] FULL_U = ACC_W'(1) << CODE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (clear) bit_q <= 1'b0;
        else if (step)  bit_q <= (last_nx > 0);
    end

    assign fb = bit_q ? signed'(FULL_U) : '0;

    p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(bit_q));
endmodule

// File: rtl/sd2_modulator.sv
`timescale 1ns/1ps
module sd2_modulator
    import sd2_pkg::*;
#(
    parameter int CODE_W = 17,
    parameter int ACC_W  = CODE_W + 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              osc_tick,
    input  logic [CODE_W-1:0] code_in,
    output logic              bit_out
);
    localparam int PAD_W = ACC_W - CODE_W;

    logic              clear, load, step;
    sd2_state_e        state;
    logic [CODE_W-1:0] code_q;
    logic signed [ACC_W-1:0] x_s, fb_s;
    logic signed [ACC_W-1:0] inc_s [LOOP_ORDER];
    logic signed [ACC_W-1:0] acc_s [LOOP_ORDER];
    logic signed [ACC_W-1:0] nx_s  [LOOP_ORDER];

    sd2_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .tick   (osc_tick),
        .clear  (clear),
        .load   (load),
        .step   (step),
        .state  (state)
    );

    // Code is captured only on tick boundaries.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     code_q <= '0;
        else if (clear) code_q <= '0;
        else if (load)  code_q <= code_in;
    end

    assign x_s = signed'({{PAD_W{1'b0}}, code_q});

    for (genvar g = 0; g < LOOP_ORDER; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign inc_s[g] = x_s - fb_s;
        end else begin : g_tail
            assign inc_s[g] = nx_s[g-1] - fb_s;
        end
        sd2_integ #(.ACC_W(ACC_W)) u_integ (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .en     (step),
            .inc    (inc_s[g]),
            .acc    (acc_s[g]),
            .acc_nx (nx_s[g])
        );
    end

    sd2_quant #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_quant (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .step    (step),
        .last_nx (nx_s[LOOP_ORDER-1]),
        .bit_q   (bit_out),
        .fb      (fb_s)
    );

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !bit_out);
    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load) |=> $stable(code_q));
    p_reset_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !bit_out);
endmodule

// File: tb/sd2_modulator_test.sv
`timescale 1ns/1ps
module sd2_modulator_test;
    localparam int CW = 10;
    localparam int AW = 17;
    localparam longint FS = 64'd1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          osc_tick = 1'b0;
    logic [CW-1:0] code_in = '0;
    logic          bit_out;

    int pass_n = 0;
    int fail_n = 0;

    // Reference model state: 0 off, 1 arm, 2 run.
    int     m_st = 0;
    longint m_cq = 0, m_i1 = 0, m_i2 = 0;
    bit     m_b = 1'b0;

    sd2_modulator #(.CODE_W(CW), .ACC_W(AW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .osc_tick (osc_tick),
        .code_in  (code_in),
        .bit_out  (bit_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        if (ok) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge(input bit en, input bit tk, input longint cd);
        longint fb;
        if (!en) begin
            m_st = 0; m_cq = 0; m_i1 = 0; m_i2 = 0; m_b = 1'b0;
        end else if (m_st == 0) begin
            m_st = 1;
        end else if (m_st == 1) begin
            if (tk) begin m_cq = cd; m_st = 2; end
        end else if (tk) begin
            fb = m_b ? FS : 0;
            m_i1 = m_i1 + m_cq - fb;
            m_i2 = m_i2 + m_i1 - fb;
            m_b = (m_i2 > 0);
            m_cq = cd;
        end
    endtask

    // One clock: drive on the falling edge, sample 1 ns after the rising edge.
    task automatic cyc(input bit en, input bit tk, input longint cd, input bit cmp, input string req);
        @(negedge clk);
        run_en = en; osc_tick = tk; code_in = CW'(cd);
        model_edge(en, tk, cd);
        @(posedge clk);
        #1;
        if (cmp) check(bit_out == m_b, req, bit_out, m_b);
    endtask

    task automatic measure(input longint cd, output int ones);
        cyc(0, 1, cd, 0, "");
        cyc(1, 1, cd, 0, "");   // OFF -> ARM
        cyc(1, 1, cd, 0, "");   // ARM: capture code
        ones = 0;
        for (int k = 0; k < FS; k++) begin
            cyc(1, 1, cd, 0, "");
            ones += bit_out;
        end
    endtask

    initial begin
        #(4 * 200000);
        fail_n++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end

    initial begin
        int ones, prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(bit_out == 1'b0, "R9 reset output", bit_out, 0);

        // R8: enable-cycle tick ignored, first ARM tick loads only, next tick steps.
        cyc(1, 1, 500, 1, "R8 enter arm");
        check(bit_out == 1'b0, "R8 tick ignored on enable", bit_out, 0);
        cyc(1, 1, 500, 1, "R8 arm load");
        check(bit_out == 1'b0, "R8 no step on load", bit_out, 0);
        cyc(1, 1, 500, 1, "R8 first step");
        check(bit_out == 1'b1, "R8 first step bit", bit_out, 1);

        // R3: zero code never emits a one.
        measure(0, ones);
        check(ones == 0, "R3 zero code ones", ones, 0);

        // R1 density and R2 monotonic sweep.
        prev = -1;
        for (int c = 160; c <= 860; c += 20) begin
            measure(c, ones);
            check((ones >= c - 2) && (ones <= c + 2), "R1 density", ones, c);
            if (prev >= 0) check(ones > prev, "R2 monotonic", ones, prev + 1);
            prev = ones;
        end

        // R4: sparse ticks, code changing every cycle; stream must follow captured codes.
        cyc(0, 0, 0, 1, "R4 clear");
        for (int k = 0; k < 300; k++)
            cyc(1, (k % 3) == 0, 160 + ((k * 97) % 700), 1, "R4 stream");

        // R5: disable and tick in the same cycle, then restart.
        cyc(0, 1, 400, 1, "R5 drop");
        check(bit_out == 1'b0, "R5 cleared on drop", bit_out, 0);
        for (int k = 0; k < 200; k++)
            cyc(1, 1, 300 + (k % 5) * 40, 1, "R5 restart");

        // R6: disabled with activity on the other inputs.
        for (int k = 0; k < 50; k++) begin
            cyc(0, k[0], (k * 211) % FS, 0, "");
            check(bit_out == 1'b0, "R6 quiet while off", bit_out, 0);
        end

        // R7: high code against unbounded arithmetic.
        for (int k = 0; k < 2048; k++)
            cyc(1, 1, 864, 1, "R7 no wrap");

        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end
endmodule